// File: doc/BRIEF.md
# Sparse Bit-Row Coordinate Encoder

This block turns one 8×8 block of binary bit-plane symbols into a serial bitstream. It works one row at a time. A row holding only zeros costs a single bit. In a row holding ones, each one is announced by a flag bit and then a location field. Later fields are narrower than earlier ones, because fewer columns are left to the right of the previous one. The block is meant for sparse planes, where most rows are empty and set symbols are rare.

A 64-bit block is captured when `start` is seen while the encoder is idle. The stream then leaves one bit per accepted cycle on `out_bit`, under a valid/ready handshake. When the last bit of the final row has been taken, `done` pulses for one cycle, and `bit_count` keeps the number of bits emitted for that block.

Top module: `bitrow_coord_enc`

## Requirements
- R1: While reset is held and directly after it, out_valid and done are low and bit_count is zero.
- R2: A start seen while out_valid is low captures block_in, and out_valid is high on the next cycle. A start seen while a stream is running is ignored, and the running stream is unchanged.
- R3: A row containing no ones is coded as the single bit 0.
- R4: Bit r*8+c of block_in is the symbol in row r, column c. Rows are coded in ascending order and columns are scanned in ascending order. The first one in a row is coded as a 1, followed by its column as a 3-bit field sent MSB first.
- R5: Each later one at column c, following a one at column p, is coded as a 1 and then a field of ceil(log2(7-p)) bits, sent MSB first, that holds c-p-1.
- R6: After a one at column 6 the field width is zero, so a one at column 7 is coded as the single bit 1.
- R7: After the last one of a row a 0 bit follows, except when that last one sits in column 7, in which case nothing follows.
- R8: While out_valid is high and out_ready is low, out_valid and out_bit hold. A bit is consumed only in a cycle where both are high.
- R9: bit_count is cleared by an accepted start, rises by one for each accepted bit, and saturates at 2^CNT_W-1.
- R10: done is high for exactly one cycle, the cycle after the edge that accepts the final bit of the last row, and out_valid is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture block_in and begin encoding (only when idle) |
| block_in | input | 64 | Block symbols, bit r*8+c is row r column c |
| out_bit | output | 1 | Current stream bit |
| out_valid | output | 1 | out_bit holds a bit to consume |
| out_ready | input | 1 | Consumer takes out_bit this cycle |
| done | output | 1 | One-cycle pulse after the final bit is accepted |
| bit_count | output | 10 | Bits emitted for the current block, saturating |

## Verification
The empty block checks that an empty row codes to one bit. A single one swept through every column of a row separates the absolute first field from the omitted terminator at column 7. Two fixed rows pin the shrinking field widths: ones at columns 3, 5 and 6, and ones at 6 and 7, where the field has zero width. A sweep puts all 256 row values into changing row positions, with and without a randomly stalling consumer, and compares each stream bit by bit with a model computed in the bench. That sweep catches wrong gaps, wrong widths, wrong row order and bits lost under back-pressure. A dense all-ones block on a narrow counter shows saturation, and a start pulsed in the middle of a stream shows that the running block is kept.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_FIELD = 2'd2
  } enc_state_e;

  // smallest w with 2**w >= n
  function automatic int unsigned ceil_log2(input int unsigned n);
    int unsigned w;
    w = 0;
    for (int i = 0; i < 31; i++) begin
      if ((32'd1 << i) < n) w = i + 1;
    end
    return w;
  endfunction

  // width of the location field for the next one in a row
  function automatic int unsigned loc_width(input bit first, input int unsigned prev,
                                            input int unsigned cols);
    if (first) return ceil_log2(cols);
    return ceil_log2(cols - 1 - prev);
  endfunction

  // value carried by that field: absolute column first, then gap
  function automatic int unsigned loc_value(input bit first, input int unsigned prev,
                                            input int unsigned col);
    if (first) return col;
    return col - prev - 1;
  endfunction

endpackage

// File: rtl/bcr_next_one.sv
module bcr_next_one #(
  parameter int COLS = 8,
  localparam int CW  = $clog2(COLS)
) (
  input  logic [COLS-1:0] row_bits,
  input  logic [CW-1:0]   from_col,
  output logic            found,
  output logic [CW-1:0]   hit_col
);

  logic [COLS-1:0] masked;

  for (genvar g = 0; g < COLS; g++) begin : g_mask
    assign masked[g] = row_bits[g] && (from_col <= CW'(g));
  end

  always_comb begin
    found   = 1'b0;
    hit_col = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (masked[i]) begin
        found   = 1'b1;
        hit_col = CW'(i);
      end
    end
  end

endmodule

// File: rtl/bcr_field_shift.sv
module bcr_field_shift #(
  parameter int FW = 3,
  localparam int WW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_val,
  input  logic [WW-1:0] load_w,
  input  logic          shift,
  output logic          bit_o,
  output logic          last_o
);

  logic [FW-1:0] val_q;
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      val_q <= load_val << (WW'(FW) - load_w);
      cnt_q <= load_w;
    end else if (shift && cnt_q != '0) begin
      val_q <= val_q << 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_o  = val_q[FW-1];
  assign last_o = (cnt_q == WW'(1));

endmodule

// File: rtl/bcr_bit_counter.sv
module bcr_bit_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                         count <= '0;
    else if (clear)                     count <= '0;
    else if (inc && count != CNT_MAX)   count <= count + 1'b1;
  end

endmodule

// File: rtl/bitrow_coord_enc.sv
module bitrow_coord_enc
  import bcr_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int CNT_W = 10,
  localparam int CW   = $clog2(COLS),
  localparam int RW   = $clog2(ROWS),
  localparam int BLK  = ROWS * COLS,
  localparam int FW   = CW,
  localparam int WW   = $clog2(FW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK-1:0]   block_in,
  output logic             out_bit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             done,
  output logic [CNT_W-1:0] bit_count
);

  enc_state_e    state_q;
  logic [BLK-1:0] blk_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] pos_q;
  logic [CW-1:0] prev_q;
  logic [CW-1:0] cur_q;
  logic          first_q;
  logic          done_q;

  // named events
  logic [COLS-1:0] row_bits;
  logic            found;
  logic [CW-1:0]   hit_col;
  logic [WW-1:0]   hit_w;
  logic [FW-1:0]   hit_v;
  logic            acc;
  logic            start_take;
  logic            ev_lead_acc;
  logic            ev_one;
  logic            ev_field_acc;
  logic            field_done;
  logic            one_closed;
  logic [CW-1:0]   one_col;
  logic            row_end;
  logic            ev_last;
  logic            fs_bit;
  logic            fs_last;

  assign row_bits = blk_q[row_q * COLS +: COLS];

  bcr_next_one #(.COLS(COLS)) u_find (
    .row_bits (row_bits),
    .from_col (pos_q),
    .found    (found),
    .hit_col  (hit_col)
  );

  assign hit_w = WW'(loc_width(first_q, 32'(prev_q), COLS));
  assign hit_v = FW'(loc_value(first_q, 32'(prev_q), 32'(hit_col)));

  assign out_valid    = (state_q != ST_IDLE);
  assign acc          = out_valid && out_ready;
  assign start_take   = start && (state_q == ST_IDLE);
  assign ev_lead_acc  = acc && (state_q == ST_LEAD);
  assign ev_one       = ev_lead_acc && found;
  assign ev_field_acc = acc && (state_q == ST_FIELD);
  assign field_done   = ev_field_acc && fs_last;
  assign one_closed   = (ev_one && hit_w == '0) || field_done;
  assign one_col      = (state_q == ST_LEAD) ? hit_col : cur_q;
  assign row_end      = (ev_lead_acc && !found) ||
                        (one_closed && one_col == CW'(COLS - 1));
  assign ev_last      = row_end && (row_q == RW'(ROWS - 1));

  bcr_field_shift #(.FW(FW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_one && hit_w != '0),
    .load_val (hit_v),
    .load_w   (hit_w),
    .shift    (ev_field_acc),
    .bit_o    (fs_bit),
    .last_o   (fs_last)
  );

  always_comb begin
    case (state_q)
      ST_LEAD:  out_bit = found;
      ST_FIELD: out_bit = fs_bit;
      default:  out_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      row_q   <= '0;
      pos_q   <= '0;
      prev_q  <= '0;
      cur_q   <= '0;
      first_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= ev_last;
      if (start_take) begin
        state_q <= ST_LEAD;
        blk_q   <= block_in;
        row_q   <= '0;
        pos_q   <= '0;
        prev_q  <= '0;
        first_q <= 1'b1;
      end else if (row_end) begin
        if (ev_last) begin
          state_q <= ST_IDLE;
        end else begin
          state_q <= ST_LEAD;
          row_q   <= row_q + 1'b1;
          pos_q   <= '0;
          prev_q  <= '0;
          first_q <= 1'b1;
        end
      end else if (one_closed) begin
        state_q <= ST_LEAD;
        pos_q   <= one_col + 1'b1;
        prev_q  <= one_col;
        first_q <= 1'b0;
      end else if (ev_one) begin
        state_q <= ST_FIELD;
        cur_q   <= hit_col;
      end
    end
  end

  assign done = done_q;

  bcr_bit_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_take),
    .inc   (acc),
    .count (bit_count)
  );

endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             out_bit,
  input logic             out_valid,
  input logic             out_ready,
  input logic             done,
  input logic [CNT_W-1:0] bit_count
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  assert_start_opens_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !out_valid) |=> out_valid);

  assert_stall_holds_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  assert_stall_holds_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_bit));

  assert_count_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && bit_count != CNT_TOP) |=> bit_count == $past(bit_count) + 1'b1);

  assert_count_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_count == CNT_TOP && !(start && !out_valid)) |=> bit_count == CNT_TOP);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

endmodule

bind bitrow_coord_enc bcr_checker #(.CNT_W(CNT_W)) u_bcr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .out_bit   (out_bit),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .done      (done),
  .bit_count (bit_count)
);

// File: tb/bitrow_coord_enc_bench.sv
module bitrow_coord_enc_bench;

  localparam int CNT_W   = 10;
  localparam int SMALL_W = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, out_ready, out_bit, out_valid, done;
  logic [63:0] block_in;
  logic [CNT_W-1:0] bit_count;

  logic        start_s, out_bit_s, out_valid_s, done_s;
  logic [SMALL_W-1:0] bit_count_s;

  bitrow_coord_enc u_bitrow_coord_enc (
    .clk(clk), .rst_n(rst_n), .start(start), .block_in(block_in),
    .out_bit(out_bit), .out_valid(out_valid), .out_ready(out_ready),
    .done(done), .bit_count(bit_count)
  );

  bitrow_coord_enc #(.CNT_W(SMALL_W)) u_bitrow_coord_enc_sat (
    .clk(clk), .rst_n(rst_n), .start(start_s), .block_in(64'hFFFF_FFFF_FFFF_FFFF),
    .out_bit(out_bit_s), .out_valid(out_valid_s), .out_ready(1'b1),
    .done(done_s), .bit_count(bit_count_s)
  );

  int checks = 0;
  int fails  = 0;
  bit exp_bits [0:511];
  bit got_bits [0:511];
  int exp_len;
  int got_len;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int bits_for(input int n);
    int w = 0;
    while ((1 << w) < n) w++;
    return w;
  endfunction

  task automatic build_ref(input logic [63:0] blk);
    exp_len = 0;
    for (int r = 0; r < 8; r++) begin
      int prev = -1;
      for (int c = 0; c < 8; c++) begin
        if (blk[r*8+c]) begin
          int w, v;
          exp_bits[exp_len] = 1'b1; exp_len++;
          if (prev < 0) begin w = 3; v = c; end
          else begin w = bits_for(7 - prev); v = c - prev - 1; end
          for (int k = w - 1; k >= 0; k--) begin
            exp_bits[exp_len] = ((v >> k) & 1) != 0; exp_len++;
          end
          prev = c;
        end
      end
      if (prev != 7) begin exp_bits[exp_len] = 1'b0; exp_len++; end
    end
  endtask

  task automatic run_block(input logic [63:0] blk, input bit stall, input bit poke,
                           input string req);
    bit seen_done = 0;
    bit last_acc  = 0;
    bit prev_stall = 0;
    bit prev_bit  = 0;
    int cyc = 0;
    int bad = -1;
    build_ref(blk);
    @(negedge clk);
    block_in = blk; start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0; block_in = ~blk;
    check(out_valid === 1'b1, "R2", "valid after start", out_valid, 1);
    got_len = 0;
    while (cyc < 2000) begin
      bit r;
      if (done) begin
        seen_done = 1;
        check(last_acc, "R10", "done follows final accept", last_acc, 1);
        check(out_valid === 1'b0, "R10", "valid low with done", out_valid, 0);
        break;
      end
      if (prev_stall)
        check(out_valid === 1'b1 && out_bit === prev_bit, "R8", "held bit under stall",
              out_bit, prev_bit);
      r = stall ? (lfsr[0] | lfsr[5]) : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = r;
      if (poke && cyc == 5) begin start = 1'b1; block_in = ~blk; end
      else start = 1'b0;
      last_acc = out_valid && r;
      if (last_acc && got_len < 512) begin got_bits[got_len] = out_bit; got_len++; end
      prev_stall = out_valid && !r;
      prev_bit = out_bit;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; out_ready = 1'b1;
    check(seen_done, "R10", "done seen", seen_done, 1);
    for (int i = 0; i < exp_len && i < got_len; i++)
      if (bad < 0 && got_bits[i] != exp_bits[i]) bad = i;
    check(got_len == exp_len, req, "stream length", got_len, exp_len);
    check(bad < 0, req, "first bit mismatch index", bad, -1);
    check(bit_count == CNT_W'(exp_len), "R9", "bit count", bit_count, exp_len);
    @(negedge clk);
    check(done === 1'b0, "R10", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0; block_in = '0; start_s = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && done === 1'b0 && bit_count == '0, "R1",
          "state in reset", {out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && done === 1'b0 && bit_count == '0, "R1",
          "state after reset", bit_count, 0);

    run_block(64'h0, 0, 0, "R3");
    for (int c = 0; c < 8; c++) run_block(64'h1 << c, 0, 0, "R4 R7");
    run_block(64'h1 << (7*8 + 2), 0, 0, "R4");
    run_block({8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'b0110_1000, 8'h0, 8'h0}, 0, 0, "R5");
    run_block({8'h0, 8'h0, 8'b1100_0000, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0}, 0, 0, "R6");
    run_block(64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R8");
    run_block(64'h0123_4567_89AB_CDEF, 0, 1, "R2");

    for (int p = 0; p < 256; p++) begin
      logic [63:0] b = '0;
      b[(p % 8) * 8 +: 8]       = 8'(p);
      b[((p + 3) % 8) * 8 +: 8] = 8'(p) ^ 8'hA5;
      run_block(b, p[0], 0, "R5 R7");
    end

    @(negedge clk); start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
    for (int i = 0; i < 1000 && !done_s; i++) @(negedge clk);
    check(done_s === 1'b1, "R9", "saturating run finished", done_s, 1);
    check(bit_count_s == '1, "R9", "saturated count", bit_count_s, 127);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule